// File: doc/BRIEF.md
# Interrupt Deactivate Write Controller

This block takes a 32-bit software write to the CPU-interface register that deactivates one interrupt when priority drop and deactivation are separate steps. In one combinational pass it decides what the write turns into. The outcome depends on the current exception level and a set of hypervisor, monitor and enable controls. The write can be undefined, trapped to EL2, trapped to EL3, forwarded to the virtual interface, or applied to the physical interface. Trap outcomes carry a syndrome code.

For a physical write, the block masks the interrupt ID to the implemented width, which is either 16 or 24 bits. It then applies the deactivation rules of the current EOI mode to a table of per-interrupt active flags and per-priority active bits. Acknowledge and EOI inputs maintain that table. This lets a system or a bench put the deactivation either before or after the priority drop.

Top module: `deact_ctrl`

## Requirements
- R1: `res_o` is one-hot or zero, with bit 0 = undefined, bit 1 = trap to EL2, bit 2 = trap to EL3, bit 3 = virtual write and bit 4 = physical write. It is set for exactly the cycle after a write is accepted (`wr_valid_i` high at a clock edge) and is zero otherwise.
- R2: A write with `el_i` = 0 always gives undefined.
- R3: A write with `el_i` = 1 takes the first matching rule in this order:
  - the hypervisor group trap gives trap to EL2;
  - the hypervisor deactivate trap or common trap gives trap to EL2;
  - FIQ or IRQ routing to the hypervisor gives virtual;
  - the monitor routing both IRQ and FIQ gives trap to EL3;
  - anything else gives physical.
  The first three rules apply only when `el2_en_i` is set. The fourth applies only when `el3_en_i` is set.
- R4: `syndrome_o` is valid in the same cycle as `res_o`.
  - A trap to EL2 gives 0x03.
  - A trap to EL3 gives 0x03 when `mon_64_i` is set and 0x00 when it is clear.
  - Every other outcome, and the idle state, gives 0x00.
- R5: A write with `el_i` = 2 is undefined when `el2_sre_i` is 0. Otherwise it traps to EL3 when the monitor (enabled) routes both IRQ and FIQ, and is physical in all other cases.
- R6: A write with `el_i` = 3 is undefined when `el3_sre_i` is 0 and physical otherwise.
- R7: The interrupt ID is taken from bits [23:0] of `wr_data_i`, and bits [31:24] are ignored. When `id_wide_i` is 0, bits [23:16] are also forced to zero.
- R8: A physical write whose masked ID is 32 or more changes no state.
- R9: With `eoi_mode_i` = 0, a physical write changes no state and pulses `serr_o` for one cycle, aligned with `res_o`.
- R10: With `eoi_mode_i` = 1, a physical write clears the active flag of its ID in the next cycle and leaves `apr_o` unchanged. This holds whether or not an EOI has already been issued.
- R11: An acknowledge (`ack_i`) sets `active_o[ack_id_i]` and `apr_o[ack_prio_i]` in the next cycle.
- R12: An EOI (`eoi_i`) clears the lowest-index set bit of `apr_o`, where index 0 is the highest priority. It does nothing when `apr_o` is zero and never alters `active_o`.
- R13: Undefined, trapped and virtual outcomes change no state and do not pulse `serr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Written word |
| el_i | input | 2 | Current exception level |
| id_wide_i | input | 1 | 1: 24-bit IDs, 0: 16-bit IDs |
| eoi_mode_i | input | 1 | 1: priority drop and deactivation split |
| el2_en_i | input | 1 | EL2 enabled |
| hyp_grp_trap_i | input | 1 | Hypervisor register-group trap |
| hyp_dir_trap_i | input | 1 | Hypervisor deactivate trap |
| hyp_cmn_trap_i | input | 1 | Hypervisor common trap |
| hyp_fiq_rt_i | input | 1 | FIQ routed to hypervisor |
| hyp_irq_rt_i | input | 1 | IRQ routed to hypervisor |
| el3_en_i | input | 1 | EL3 implemented |
| mon_irq_rt_i | input | 1 | IRQ routed to monitor |
| mon_fiq_rt_i | input | 1 | FIQ routed to monitor |
| mon_64_i | input | 1 | Monitor runs in 64-bit state |
| el2_sre_i | input | 1 | EL2 system-register enable |
| el3_sre_i | input | 1 | EL3 system-register enable |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| ack_id_i | input | 5 | Acknowledged interrupt ID |
| ack_prio_i | input | 3 | Acknowledged priority level |
| eoi_i | input | 1 | Priority drop strobe |
| res_o | output | 5 | One-hot write outcome |
| syndrome_o | output | 6 | Trap syndrome code |
| serr_o | output | 1 | Ignored-write system error pulse |
| active_o | output | 32 | Per-interrupt active flags |
| apr_o | output | 8 | Per-priority active bits |

## Verification
A wrong routing decision shows at `res_o` one cycle after the write, and a wrong trap code shows on `syndrome_o` in that same cycle. The full sweep over exception levels and control bits exposes any misordered rule at once. A corrupted active table or priority-bit register appears on `active_o` or `apr_o` one cycle after the acknowledge, EOI or deactivation that caused it. The bench keeps its own model of both and compares them after every operation, so a divergence is reported at the first operation that produces it.

// File: rtl/deact_pkg.sv
package deact_pkg;
  localparam int RES_W     = 5;
  localparam int RES_UNDEF = 0;
  localparam int RES_TRAP2 = 1;
  localparam int RES_TRAP3 = 2;
  localparam int RES_VIRT  = 3;
  localparam int RES_PHYS  = 4;

  localparam int EC_W = 6;
  localparam logic [EC_W-1:0] EC_SYSREG = 6'h03;

  typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3} lvl_e;

  typedef struct packed {
    logic el2_en;
    logic grp_trap;
    logic dir_trap;
    logic cmn_trap;
    logic fiq_rt;
    logic irq_rt;
    logic el3_en;
    logic mon_irq;
    logic mon_fiq;
    logic mon_64;
    logic el2_sre;
    logic el3_sre;
  } route_ctl_t;
endpackage

// File: rtl/deact_route.sv
module deact_route
  import deact_pkg::*;
(
  input  logic [1:0]      el_i,
  input  route_ctl_t      ctl_i,
  output logic [RES_W-1:0] res_o,
  output logic [EC_W-1:0]  synd_o
);
  logic mon_both;
  assign mon_both = ctl_i.el3_en & ctl_i.mon_irq & ctl_i.mon_fiq;

  always_comb begin
    res_o = '0;
    unique case (lvl_e'(el_i))
      LVL0: res_o[RES_UNDEF] = 1'b1;
      LVL1: begin
        // first match wins
        if (ctl_i.el2_en && ctl_i.grp_trap)                       res_o[RES_TRAP2] = 1'b1;
        else if (ctl_i.el2_en && (ctl_i.dir_trap || ctl_i.cmn_trap)) res_o[RES_TRAP2] = 1'b1;
        else if (ctl_i.el2_en && (ctl_i.fiq_rt || ctl_i.irq_rt))     res_o[RES_VIRT]  = 1'b1;
        else if (mon_both)                                           res_o[RES_TRAP3] = 1'b1;
        else                                                         res_o[RES_PHYS]  = 1'b1;
      end
      LVL2: begin
        if (!ctl_i.el2_sre) res_o[RES_UNDEF] = 1'b1;
        else if (mon_both)  res_o[RES_TRAP3] = 1'b1;
        else                res_o[RES_PHYS]  = 1'b1;
      end
      default: begin
        if (!ctl_i.el3_sre) res_o[RES_UNDEF] = 1'b1;
        else                res_o[RES_PHYS]  = 1'b1;
      end
    endcase
  end

  always_comb begin
    synd_o = '0;
    if (res_o[RES_TRAP2])                       synd_o = EC_SYSREG;
    else if (res_o[RES_TRAP3] && ctl_i.mon_64)  synd_o = EC_SYSREG;
  end
endmodule

// File: rtl/deact_state.sv
module deact_state #(
  parameter int NUM_IRQ     = 32,
  parameter int NUM_PRIO    = 8,
  parameter int ID_W        = 24,
  parameter int NARROW_ID_W = 16,
  localparam int IRQ_W      = $clog2(NUM_IRQ),
  localparam int PRIO_W     = $clog2(NUM_PRIO)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                deact_i,
  input  logic                eoi_mode_i,
  input  logic                id_wide_i,
  input  logic [ID_W-1:0]     wr_id_i,
  input  logic                ack_i,
  input  logic [IRQ_W-1:0]    ack_id_i,
  input  logic [PRIO_W-1:0]   ack_prio_i,
  input  logic                eoi_i,
  output logic [NUM_IRQ-1:0]  active_o,
  output logic [NUM_PRIO-1:0] apr_o,
  output logic                serr_o
);
  logic [ID_W-1:0]     id_m;
  logic                in_range;
  logic [NUM_IRQ-1:0]  active_q, active_d;
  logic [NUM_PRIO-1:0] apr_q, apr_d, apr_low;
  logic                serr_q;

  // upper ID bits survive only in wide mode
  for (genvar b = 0; b < ID_W; b++) begin : g_mask
    if (b < NARROW_ID_W) begin : g_keep
      assign id_m[b] = wr_id_i[b];
    end else begin : g_gate
      assign id_m[b] = wr_id_i[b] & id_wide_i;
    end
  end

  assign in_range = id_m < ID_W'(NUM_IRQ);
  assign apr_low  = apr_q & (~apr_q + NUM_PRIO'(1));

  always_comb begin
    active_d = active_q;
    apr_d    = apr_q;
    if (eoi_i) apr_d = apr_d & ~apr_low;
    if (ack_i) begin
      active_d[ack_id_i] = 1'b1;
      apr_d[ack_prio_i]  = 1'b1;
    end
    if (deact_i && eoi_mode_i && in_range) active_d[id_m[IRQ_W-1:0]] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      apr_q    <= '0;
      serr_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      apr_q    <= apr_d;
      serr_q   <= deact_i & ~eoi_mode_i;
    end
  end

  assign active_o = active_q;
  assign apr_o    = apr_q;
  assign serr_o   = serr_q;
endmodule

// File: rtl/deact_ctrl.sv
module deact_ctrl
  import deact_pkg::*;
#(
  parameter int NUM_IRQ     = 32,
  parameter int NUM_PRIO    = 8,
  parameter int DATA_W      = 32,
  parameter int ID_W        = 24,
  parameter int NARROW_ID_W = 16,
  localparam int IRQ_W      = $clog2(NUM_IRQ),
  localparam int PRIO_W     = $clog2(NUM_PRIO)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_valid_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [1:0]          el_i,
  input  logic                id_wide_i,
  input  logic                eoi_mode_i,
  input  logic                el2_en_i,
  input  logic                hyp_grp_trap_i,
  input  logic                hyp_dir_trap_i,
  input  logic                hyp_cmn_trap_i,
  input  logic                hyp_fiq_rt_i,
  input  logic                hyp_irq_rt_i,
  input  logic                el3_en_i,
  input  logic                mon_irq_rt_i,
  input  logic                mon_fiq_rt_i,
  input  logic                mon_64_i,
  input  logic                el2_sre_i,
  input  logic                el3_sre_i,
  input  logic                ack_i,
  input  logic [IRQ_W-1:0]    ack_id_i,
  input  logic [PRIO_W-1:0]   ack_prio_i,
  input  logic                eoi_i,
  output logic [RES_W-1:0]    res_o,
  output logic [EC_W-1:0]     syndrome_o,
  output logic                serr_o,
  output logic [NUM_IRQ-1:0]  active_o,
  output logic [NUM_PRIO-1:0] apr_o
);
  route_ctl_t       ctl;
  logic [RES_W-1:0] res_c, res_q;
  logic [EC_W-1:0]  synd_c, synd_q;
  logic             unused_rsvd;

  assign ctl = '{el2_en: el2_en_i, grp_trap: hyp_grp_trap_i, dir_trap: hyp_dir_trap_i,
                 cmn_trap: hyp_cmn_trap_i, fiq_rt: hyp_fiq_rt_i, irq_rt: hyp_irq_rt_i,
                 el3_en: el3_en_i, mon_irq: mon_irq_rt_i, mon_fiq: mon_fiq_rt_i,
                 mon_64: mon_64_i, el2_sre: el2_sre_i, el3_sre: el3_sre_i};

  // reserved top bits of the written word
  assign unused_rsvd = ^wr_data_i[DATA_W-1:ID_W];

  deact_route u_route (
    .el_i   (el_i),
    .ctl_i  (ctl),
    .res_o  (res_c),
    .synd_o (synd_c)
  );

  deact_state #(
    .NUM_IRQ     (NUM_IRQ),
    .NUM_PRIO    (NUM_PRIO),
    .ID_W        (ID_W),
    .NARROW_ID_W (NARROW_ID_W)
  ) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .deact_i    (wr_valid_i & res_c[RES_PHYS]),
    .eoi_mode_i (eoi_mode_i),
    .id_wide_i  (id_wide_i),
    .wr_id_i    (wr_data_i[ID_W-1:0]),
    .ack_i      (ack_i),
    .ack_id_i   (ack_id_i),
    .ack_prio_i (ack_prio_i),
    .eoi_i      (eoi_i),
    .active_o   (active_o),
    .apr_o      (apr_o),
    .serr_o     (serr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      synd_q <= '0;
    end else begin
      res_q  <= wr_valid_i ? res_c  : '0;
      synd_q <= wr_valid_i ? synd_c : '0;
    end
  end

  assign res_o      = res_q;
  assign syndrome_o = synd_q;
endmodule

// File: rtl/deact_ctrl_chk.sv
module deact_ctrl_chk #(
  parameter int NUM_IRQ  = 32,
  parameter int NUM_PRIO = 8,
  parameter int DATA_W   = 32,
  localparam int IRQ_W   = $clog2(NUM_IRQ),
  localparam int PRIO_W  = $clog2(NUM_PRIO)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_valid_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic [1:0]          el_i,
  input logic                id_wide_i,
  input logic                eoi_mode_i,
  input logic                el2_en_i,
  input logic                hyp_grp_trap_i,
  input logic                hyp_dir_trap_i,
  input logic                hyp_cmn_trap_i,
  input logic                hyp_fiq_rt_i,
  input logic                hyp_irq_rt_i,
  input logic                el3_en_i,
  input logic                mon_irq_rt_i,
  input logic                mon_fiq_rt_i,
  input logic                mon_64_i,
  input logic                el2_sre_i,
  input logic                el3_sre_i,
  input logic                ack_i,
  input logic [IRQ_W-1:0]    ack_id_i,
  input logic [PRIO_W-1:0]   ack_prio_i,
  input logic                eoi_i,
  input logic [4:0]          res_o,
  input logic [5:0]          syndrome_o,
  input logic                serr_o,
  input logic [NUM_IRQ-1:0]  active_o,
  input logic [NUM_PRIO-1:0] apr_o
);
  assert_res_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(res_o));

  assert_res_after_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> (res_o != 5'b0));

  assert_res_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> (res_o == 5'b0));

  assert_el0_undef_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && el_i == 2'd0) |=> (res_o == 5'b00001));

  assert_synd_trap_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syndrome_o != 6'h0) |-> (res_o[1] || res_o[2]));

  assert_el3_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && el_i == 2'd3) |=> (res_o == (el3_sre_q ? 5'b10000 : 5'b00001)));

  assert_serr_align_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !eoi_mode_i) |=> (serr_o == res_o[4]));

  assert_apr_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eoi_i && !ack_i) |=> $stable(apr_o));

  assert_nonphys_keep_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !ack_i) |=> (res_o[4] || $stable(active_o)));

  assert_eoi_one_bit_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && apr_o != '0) |=> ($countones(apr_o) + 1 == $countones($past(apr_o))));

  logic el3_sre_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) el3_sre_q <= 1'b0;
    else         el3_sre_q <= el3_sre_i;
  end
endmodule

bind deact_ctrl deact_ctrl_chk #(
  .NUM_IRQ  (NUM_IRQ),
  .NUM_PRIO (NUM_PRIO),
  .DATA_W   (DATA_W)
) u_chk (.*);

// File: tb/deact_ctrl_test.sv
`timescale 1ns/1ps
module deact_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  el = '0;
  logic        id_wide = 1'b0, eoi_mode = 1'b0;
  logic        el2_en = 0, grp = 0, dirt = 0, cmn = 0, fiq = 0, irq = 0;
  logic        el3_en = 0, mirq = 0, mfiq = 0, m64 = 0, sre2 = 0, sre3 = 0;
  logic        ack = 0, eoi = 0;
  logic [4:0]  ack_id = '0;
  logic [2:0]  ack_prio = '0;
  logic [4:0]  res;
  logic [5:0]  synd;
  logic        serr;
  logic [31:0] active;
  logic [7:0]  apr;

  int tot = 0, bad = 0;
  logic [31:0] m_act = '0;
  logic [7:0]  m_apr = '0;

  always #2 clk = ~clk;

  deact_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .el_i(el), .id_wide_i(id_wide), .eoi_mode_i(eoi_mode), .el2_en_i(el2_en),
    .hyp_grp_trap_i(grp), .hyp_dir_trap_i(dirt), .hyp_cmn_trap_i(cmn),
    .hyp_fiq_rt_i(fiq), .hyp_irq_rt_i(irq), .el3_en_i(el3_en),
    .mon_irq_rt_i(mirq), .mon_fiq_rt_i(mfiq), .mon_64_i(m64),
    .el2_sre_i(sre2), .el3_sre_i(sre3), .ack_i(ack), .ack_id_i(ack_id),
    .ack_prio_i(ack_prio), .eoi_i(eoi), .res_o(res), .syndrome_o(synd),
    .serr_o(serr), .active_o(active), .apr_o(apr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tot++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // outcome computed from the written rules: 1 undef,2 trap2,4 trap3,8 virt,16 phys
  function automatic logic [4:0] exp_res();
    logic mon = el3_en & mirq & mfiq;
    case (el)
      2'd0: return 5'd1;
      2'd1: begin
        if (el2_en & (grp | dirt | cmn)) return 5'd2;
        if (el2_en & (fiq | irq))        return 5'd8;
        return mon ? 5'd4 : 5'd16;
      end
      2'd2: return !sre2 ? 5'd1 : (mon ? 5'd4 : 5'd16);
      default: return sre3 ? 5'd16 : 5'd1;
    endcase
  endfunction

  task automatic do_write(input logic [31:0] d, input string tag);
    logic [4:0] er;
    logic [31:0] id;
    er = exp_res();
    id = id_wide ? {8'h0, d[23:0]} : {16'h0, d[15:0]};
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    if (er == 5'd16 && eoi_mode && id < 32) m_act[id] = 1'b0;
    chk({tag, " res"}, 32'(res), 32'(er));
    chk("R9 serr", 32'(serr), 32'(er == 5'd16 && !eoi_mode));
    chk({tag, " active"}, active, m_act);
    chk("R10 apr", 32'(apr), 32'(m_apr));
  endtask

  task automatic do_ack(input int id, input int pr);
    @(negedge clk);
    ack = 1'b1; ack_id = 5'(id); ack_prio = 3'(pr);
    @(negedge clk);
    ack = 1'b0;
    m_act[id] = 1'b1; m_apr[pr] = 1'b1;
    chk("R11 ack active", active, m_act);
    chk("R11 ack apr", 32'(apr), 32'(m_apr));
  endtask

  task automatic do_eoi();
    @(negedge clk);
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    m_apr = m_apr & ~(m_apr & (~m_apr + 8'd1));
    chk("R12 eoi apr", 32'(apr), 32'(m_apr));
    chk("R12 eoi active", active, m_act);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tot++; bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset res", 32'(res), 0);
    chk("R4 reset synd", 32'(synd), 0);
    chk("R11 reset active", active, 0);
    chk("R12 reset apr", 32'(apr), 0);

    // full routing sweep, EOI mode 0 so no state moves
    for (int v = 0; v < 16384; v++) begin
      logic [4:0] er;
      logic [5:0] es;
      {sre3, sre2, m64, mfiq, mirq, el3_en, irq, fiq, cmn, dirt, grp, el2_en, el} = 14'(v);
      er = exp_res();
      es = (er == 5'd2 || (er == 5'd4 && m64)) ? 6'h03 : 6'h00;
      @(negedge clk);
      wr_valid = 1'b1; wr_data = 32'h0000_0003;
      @(negedge clk);
      wr_valid = 1'b0;
      case (el)
        2'd0: chk("R2 el0 route", 32'(res), 32'(er));
        2'd1: chk("R3 el1 route", 32'(res), 32'(er));
        2'd2: chk("R5 el2 route", 32'(res), 32'(er));
        default: chk("R6 el3 route", 32'(res), 32'(er));
      endcase
      chk("R4 syndrome", 32'(synd), 32'(es));
      chk("R9 serr sweep", 32'(serr), 32'(er == 5'd16));
    end
    @(negedge clk);
    chk("R1 idle res", 32'(res), 0);
    chk("R4 idle synd", 32'(synd), 0);
    chk("R13 sweep active", active, 0);

    // physical path at EL3
    {sre3, sre2, m64, mfiq, mirq, el3_en, irq, fiq, cmn, dirt, grp, el2_en} = '0;
    el = 2'd3; sre3 = 1'b1; eoi_mode = 1'b1;
    for (int i = 0; i < 32; i++) do_ack(i, i % 8);

    id_wide = 1'b0;
    for (int i = 0; i < 32; i += 2) do_write(32'hFF01_0000 | 32'(i), "R7 narrow mask");
    id_wide = 1'b1;
    for (int i = 1; i < 32; i += 2) do_write(32'h0001_0000 | 32'(i), "R8 out of range");
    do_write(32'hFF00_0001, "R7 reserved top");
    do_write(32'h00FF_FFFF, "R8 max id");

    eoi_mode = 1'b0;
    do_write(32'h0000_0003, "R9 mode0 ignored");
    eoi_mode = 1'b1;

    // deactivation before EOI leaves priority; then drop all
    do_write(32'h0000_0003, "R10 before eoi");
    for (int k = 0; k < 9; k++) do_eoi();

    // deactivation after EOI
    do_ack(5, 2);
    do_eoi();
    do_write(32'h0000_0005, "R10 after eoi");

    // non-physical outcomes keep state
    do_ack(9, 6);
    el = 2'd1; el2_en = 1'b1; grp = 1'b1;
    do_write(32'h0000_0009, "R13 trap2 keep");
    grp = 1'b0; irq = 1'b1;
    do_write(32'h0000_0009, "R13 virt keep");
    el = 2'd0;
    do_write(32'h0000_0009, "R13 undef keep");
    el = 2'd2; sre2 = 1'b1; el3_en = 1'b1; mirq = 1'b1; mfiq = 1'b1; m64 = 1'b1;
    do_write(32'h0000_0009, "R13 trap3 keep");
    chk("R4 trap3 64", 32'(synd), 32'h3);

    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule